// File: doc/BRIEF.md
# Processor Event Priority Arbiter

This block sits next to a small 8-bit processor core and decides, at the right boundary, which pending event the core serves next. It watches an active-low bus request from an external master, an active-low non-maskable interrupt and three active-low maskable interrupt lines. It also receives two strobes from the core, one marking the end of each machine cycle and one marking the end of each instruction. Bus requests are taken at machine-cycle ends and beat every interrupt. Interrupts are taken only at instruction ends.

When the bus is handed over, the block asserts an active-low bus acknowledge and an enable that floats the core's address, data and bus strobes. It also stops instruction execution. When an interrupt is accepted, the block emits a one-cycle acknowledge strobe with an encoded source code. A separate flag tells the core whether the acknowledge cycle must drive its opcode-fetch and I/O strobes. The block keeps the interrupt-enable flag and a flag for on-chip service in progress; that second flag gates the enable output of a daisy chain. The reset input is filtered, so that only a reset held for several clocks initialises the block.

Top module: `irq_bus_arbiter`

## Requirements
- R1: A low `busreq_n` is granted only in a cycle where `mc_end`=1 and execution is running. In the next cycle `busack_n`=0, `bus_hiz`=1 and `run_en`=0, and they hold while the request stays low. Instruction ends that arrive during the grant are ignored.
- R2: `busack_n` returns to 1 and `bus_hiz` to 0 in the cycle after `busreq_n` is sampled high. `run_en` stays 0 for that one cycle and returns to 1 in the cycle after it.
- R3: When an instruction end coincides with a low `busreq_n`, no interrupt is accepted in that cycle. A latched non-maskable request stays pending until a later instruction end.
- R4: A falling edge on `nmi_n` is latched. It is accepted at the next instruction end whatever the value of `ie`, reports `ack_sel`=1 and outranks every maskable line. Holding `nmi_n` low does not raise a second request.
- R5: Line 0 (`int_n[0]`=0) is accepted only while `ie`=1. It reports `ack_sel`=2 with `ack_m1_iorq`=1.
- R6: Lines 1 and 2 are accepted only when `ie`=1, `int_n[0]`=1, no non-maskable request is pending and `busreq_n`=1. They report `ack_sel`=3 and `ack_sel`=4 with `ack_m1_iorq`=0, and line 1 wins when both are low.
- R7: `ei_stb` sets `ie` and `di_stb` clears it. Accepting any interrupt clears `ie`, and acceptance wins over an `ei_stb` in the same cycle.
- R8: `ieo` equals `iei` AND NOT service-in-progress. Service-in-progress is set when line 0 is accepted and cleared by `reti_stb`.
- R9: The block initialises only after `rst_n` has been sampled low at 3 consecutive rising edges, and a shorter low pulse changes nothing. After initialisation: `busack_n`=1, `bus_hiz`=0, `run_en`=1, `ie`=0, `ack_stb`=0, and no service is in progress.
- R10: An acceptance raises `ack_stb` for exactly the cycle after the instruction-end cycle, with `ack_sel` holding the code (0 none, 1 non-maskable, 2 + n for line n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Raw active-low reset request, filtered inside |
| busreq_n | input | 1 | Active-low bus request from an external master |
| nmi_n | input | 1 | Active-low non-maskable interrupt, falling-edge sensitive |
| int_n | input | 3 | Active-low maskable interrupt lines, level sensitive |
| mc_end | input | 1 | Machine-cycle end strobe from the core |
| instr_end | input | 1 | Instruction end strobe from the core |
| ei_stb | input | 1 | Set interrupt-enable flag |
| di_stb | input | 1 | Clear interrupt-enable flag |
| reti_stb | input | 1 | Return from on-chip interrupt service |
| iei | input | 1 | Daisy-chain enable in |
| busack_n | output | 1 | Active-low bus acknowledge |
| bus_hiz | output | 1 | Floats the core's address, data and bus strobes |
| run_en | output | 1 | Core may execute instructions |
| ie | output | 1 | Interrupt-enable flag |
| ack_stb | output | 1 | One-cycle interrupt acceptance strobe |
| ack_sel | output | 3 | Encoded accepted source |
| ack_m1_iorq | output | 1 | Acknowledge cycle drives fetch and I/O strobes |
| ieo | output | 1 | Daisy-chain enable out |

## Verification
The hardest situation to reach is a latched non-maskable request that meets an instruction end in the very cycle the bus is claimed. The request must survive the whole grant, the reset glitches during it and the resume cycle, and only then be served. The stimulus first latches the edge while `instr_end` is held low. It then raises `mc_end` and `instr_end` together with the bus request. During the grant it injects a two-cycle reset pulse and further instruction ends. After release it expects the non-maskable acknowledge at the first instruction end once execution resumes.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    BUS_RUN    = 2'd0,
    BUS_GRANT  = 2'd1,
    BUS_RESUME = 2'd2
  } bus_st_e;

  localparam int ACK_NONE     = 0;
  localparam int ACK_NMI      = 1;
  localparam int ACK_INT_BASE = 2;

endpackage

// File: rtl/arb_rst_filter.sv
module arb_rst_filter #(
  parameter int MIN_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_req_n,
  output logic core_rst_n
);

  logic [MIN_CYCLES-1:0] hist_q;
  logic [MIN_CYCLES-1:0] hist_d;
  logic                  core_rst_n_d;

  // history of raw samples; the filter must run while the rest is held
  generate
    if (MIN_CYCLES == 1) begin : g_single
      always_comb hist_d = rst_req_n;
    end else begin : g_shift
      always_comb hist_d = {hist_q[MIN_CYCLES-2:0], rst_req_n};
    end
  endgenerate

  // reset is taken only when every sample in the window is low
  always_comb core_rst_n_d = |hist_d;

  always_ff @(posedge clk) begin
    hist_q     <= hist_d;
    core_rst_n <= core_rst_n_d;
  end

endmodule

// File: rtl/arb_bus_fsm.sv
module arb_bus_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busreq_n,
  input  logic mc_end,
  output logic busack_n,
  output logic bus_hiz,
  output logic run_en
);

  bus_st_e state_q;
  bus_st_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUS_RUN:    if (mc_end && !busreq_n) state_d = BUS_GRANT;
      BUS_GRANT:  if (busreq_n)            state_d = BUS_RESUME;
      BUS_RESUME:                          state_d = BUS_RUN;
      default:                             state_d = BUS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BUS_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    bus_hiz  = (state_q == BUS_GRANT);
    busack_n = (state_q != BUS_GRANT);
    run_en   = (state_q == BUS_RUN);
  end

  // R1
  grant_at_mc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_hiz) |-> ($past(mc_end) && !$past(busreq_n)));

  // R2
  release_then_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hiz && busreq_n) |=> (!bus_hiz && busack_n && !run_en));

endmodule

// File: rtl/arb_irq_pick.sv
module arb_irq_pick
  import arb_pkg::*;
#(
  parameter int N_INT  = 3,
  parameter int CODE_W = 3
) (
  input  logic              boundary,
  input  logic              bus_claim,
  input  logic              nmi_pend,
  input  logic              ie,
  input  logic [N_INT-1:0]  int_act,
  output logic              take,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    code = CODE_W'(ACK_NONE);
    if (boundary && !bus_claim) begin
      if (nmi_pend) begin
        code = CODE_W'(ACK_NMI);
      end else if (ie && int_act[0]) begin
        code = CODE_W'(ACK_INT_BASE);
      end else if (ie && !int_act[0]) begin
        // descending scan: the lowest-numbered active line is written last
        for (int k = N_INT - 1; k >= 1; k--) begin
          if (int_act[k]) code = CODE_W'(ACK_INT_BASE + k);
        end
      end
    end
    take = (code != CODE_W'(ACK_NONE));
  end

endmodule

// File: rtl/arb_irq_state.sv
module arb_irq_state
  import arb_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              reti_stb,
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  output logic              nmi_pend,
  output logic              ie,
  output logic              svc,
  output logic              ack_stb,
  output logic [CODE_W-1:0] ack_sel,
  output logic              ack_m1_iorq
);

  logic              nmi_q;
  logic              nmi_fall;
  logic              take_nmi;
  logic              take_int0;
  logic              nmi_pend_d;
  logic              ie_d;
  logic              svc_d;
  logic              ack_en;
  logic [CODE_W-1:0] ack_sel_d;

  always_comb begin
    nmi_fall   = nmi_q && !nmi_n;
    take_nmi   = take && (code == CODE_W'(ACK_NMI));
    take_int0  = take && (code == CODE_W'(ACK_INT_BASE));
    nmi_pend_d = nmi_fall || (nmi_pend && !take_nmi);

    if (take)        ie_d = 1'b0;
    else if (ei_stb) ie_d = 1'b1;
    else if (di_stb) ie_d = 1'b0;
    else             ie_d = ie;

    if (take_int0)     svc_d = 1'b1;
    else if (reti_stb) svc_d = 1'b0;
    else               svc_d = svc;

    // selection register loads on accept and on the cycle that clears it
    ack_en    = take || ack_stb;
    ack_sel_d = take ? code : CODE_W'(ACK_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      ie       <= 1'b0;
      svc      <= 1'b0;
      ack_stb  <= 1'b0;
    end else begin
      nmi_q    <= nmi_n;
      nmi_pend <= nmi_pend_d;
      ie       <= ie_d;
      svc      <= svc_d;
      ack_stb  <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sel     <= CODE_W'(ACK_NONE);
      ack_m1_iorq <= 1'b0;
    end else if (ack_en) begin
      ack_sel     <= ack_sel_d;
      ack_m1_iorq <= take_int0;
    end
  end

  // R7
  accept_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> !ie);

  // R5
  maskable_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && ack_sel != CODE_W'(ACK_NMI)) |-> $past(ie));

  // R8
  svc_after_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && ack_sel == CODE_W'(ACK_INT_BASE)) |-> svc);

  // R4
  nmi_pend_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && ack_sel == CODE_W'(ACK_NMI) && !$past(nmi_fall)) |-> !nmi_pend);

endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_INT          = 3,
  parameter int RST_MIN_CYCLES = 3,
  localparam int CODE_W        = $clog2(N_INT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busreq_n,
  input  logic              nmi_n,
  input  logic [N_INT-1:0]  int_n,
  input  logic              mc_end,
  input  logic              instr_end,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              reti_stb,
  input  logic              iei,
  output logic              busack_n,
  output logic              bus_hiz,
  output logic              run_en,
  output logic              ie,
  output logic              ack_stb,
  output logic [CODE_W-1:0] ack_sel,
  output logic              ack_m1_iorq,
  output logic              ieo
);

  logic              core_rst_n;
  logic              boundary;
  logic              bus_claim;
  logic [N_INT-1:0]  int_act;
  logic              take;
  logic [CODE_W-1:0] code;
  logic              nmi_pend;
  logic              svc;

  always_comb begin
    int_act   = ~int_n;
    bus_claim = !busreq_n;
    boundary  = instr_end && run_en;
    ieo       = iei && !svc;
  end

  arb_rst_filter #(.MIN_CYCLES(RST_MIN_CYCLES)) u_rst (
    .clk        (clk),
    .rst_req_n  (rst_n),
    .core_rst_n (core_rst_n)
  );

  arb_bus_fsm u_bus (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .busreq_n (busreq_n),
    .mc_end   (mc_end),
    .busack_n (busack_n),
    .bus_hiz  (bus_hiz),
    .run_en   (run_en)
  );

  arb_irq_pick #(.N_INT(N_INT), .CODE_W(CODE_W)) u_pick (
    .boundary  (boundary),
    .bus_claim (bus_claim),
    .nmi_pend  (nmi_pend),
    .ie        (ie),
    .int_act   (int_act),
    .take      (take),
    .code      (code)
  );

  arb_irq_state #(.CODE_W(CODE_W)) u_state (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .nmi_n       (nmi_n),
    .ei_stb      (ei_stb),
    .di_stb      (di_stb),
    .reti_stb    (reti_stb),
    .take        (take),
    .code        (code),
    .nmi_pend    (nmi_pend),
    .ie          (ie),
    .svc         (svc),
    .ack_stb     (ack_stb),
    .ack_sel     (ack_sel),
    .ack_m1_iorq (ack_m1_iorq)
  );

  // R10
  ack_only_while_running_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ack_stb |-> run_en);

endmodule

// File: tb/sim_irq_bus_arbiter.sv
module sim_irq_bus_arbiter;

  logic       clk = 1'b0;
  logic       rst_n, busreq_n, nmi_n, mc_end, instr_end;
  logic       ei_stb, di_stb, reti_stb, iei;
  logic [2:0] int_n;
  logic       busack_n, bus_hiz, run_en, ie, ack_stb, ack_m1_iorq, ieo;
  logic [2:0] ack_sel;

  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  irq_bus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .nmi_n(nmi_n),
    .int_n(int_n), .mc_end(mc_end), .instr_end(instr_end),
    .ei_stb(ei_stb), .di_stb(di_stb), .reti_stb(reti_stb), .iei(iei),
    .busack_n(busack_n), .bus_hiz(bus_hiz), .run_en(run_en), .ie(ie),
    .ack_stb(ack_stb), .ack_sel(ack_sel), .ack_m1_iorq(ack_m1_iorq), .ieo(ieo)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one instruction end; a non-zero code is pushed for the monitor
  task automatic boundary(input int exp);
    instr_end = 1'b1;
    if (exp != 0) exp_q.push_back(exp);
    @(negedge clk);
    instr_end = 1'b0;
    if (exp == 0) chk(ack_stb == 1'b0, "R10", "no acceptance expected", ack_stb, 0);
  endtask

  task automatic pulse_ei();
    ei_stb = 1'b1; cyc(1); ei_stb = 1'b0;
  endtask

  task automatic pulse_reti();
    reti_stb = 1'b1; cyc(1); reti_stb = 1'b0;
  endtask

  // monitor: pops the expected code on every strobe
  always @(negedge clk) begin
    if (mon_en && ack_stb) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected ack_sel", ack_sel, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(ack_sel == e[2:0], (e == 1) ? "R4" : (e == 2) ? "R5" : "R6",
            "ack_sel", ack_sel, e);
        chk(ack_m1_iorq == (e == 2), (e == 2) ? "R5" : "R6",
            "ack_m1_iorq", ack_m1_iorq, (e == 2));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; busreq_n = 1'b1; nmi_n = 1'b1; int_n = 3'b111;
    mc_end = 1'b0; instr_end = 1'b0; ei_stb = 1'b0; di_stb = 1'b0;
    reti_stb = 1'b0; iei = 1'b1;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    mon_en = 1'b1;
    // R9 reset state
    chk(busack_n == 1'b1, "R9", "busack_n after reset", busack_n, 1);
    chk(bus_hiz == 1'b0, "R9", "bus_hiz after reset", bus_hiz, 0);
    chk(run_en == 1'b1, "R9", "run_en after reset", run_en, 1);
    chk(ie == 1'b0, "R9", "ie after reset", ie, 0);
    chk(ieo == 1'b1, "R9", "ieo after reset", ieo, 1);

    // R5 line 0 masked while ie=0
    int_n = 3'b110;
    boundary(0);
    chk(ie == 1'b0, "R5", "ie still clear", ie, 0);

    // R7 ei sets the flag
    pulse_ei();
    chk(ie == 1'b1, "R7", "ie after ei_stb", ie, 1);

    // R7 acceptance wins over ei_stb in the same cycle; R5 line 0 taken
    ei_stb = 1'b1;
    boundary(2);
    ei_stb = 1'b0;
    chk(ie == 1'b0, "R7", "ie after accept with ei_stb", ie, 0);
    chk(ieo == 1'b0, "R8", "ieo during line0 service", ieo, 0);
    int_n = 3'b111;
    pulse_reti();
    chk(ieo == 1'b1, "R8", "ieo after reti_stb", ieo, 1);
    iei = 1'b0;
    #1;
    chk(ieo == 1'b0, "R8", "ieo follows iei low", ieo, 0);
    iei = 1'b1;

    // R6 line 1 beats line 2, no fetch strobes, no service flag
    pulse_ei();
    int_n = 3'b001;
    boundary(3);
    chk(ieo == 1'b1, "R8", "ieo unaffected by line1", ieo, 1);
    pulse_ei();
    int_n = 3'b011;
    boundary(4);
    // R6 line 0 outranks line 1
    pulse_ei();
    int_n = 3'b100;
    boundary(2);
    int_n = 3'b111;
    pulse_reti();

    // R7 di clears; R6 line 1 then masked
    pulse_ei();
    di_stb = 1'b1; cyc(1); di_stb = 1'b0;
    chk(ie == 1'b0, "R7", "ie after di_stb", ie, 0);
    int_n = 3'b101;
    boundary(0);
    int_n = 3'b111;

    // R4 non-maskable edge latched, taken with ie=0
    nmi_n = 1'b0; cyc(1); nmi_n = 1'b1;
    cyc(2);
    boundary(1);
    nmi_n = 1'b0; cyc(1);
    boundary(1);
    boundary(0); // R4 level held low, no second request
    nmi_n = 1'b1;

    // R4 non-maskable outranks line 0
    pulse_ei();
    int_n = 3'b110;
    nmi_n = 1'b0; cyc(1); nmi_n = 1'b1;
    boundary(1);
    pulse_ei();
    boundary(2);
    int_n = 3'b111;
    pulse_reti();

    // R1 request without machine-cycle end is not granted
    nmi_n = 1'b0; cyc(1); nmi_n = 1'b1;
    busreq_n = 1'b0;
    cyc(2);
    chk(busack_n == 1'b1, "R1", "no grant without mc_end", busack_n, 1);
    // R3 grant and instruction end together, pending NMI kept
    mc_end = 1'b1; instr_end = 1'b1;
    cyc(1);
    mc_end = 1'b0; instr_end = 1'b0;
    chk(ack_stb == 1'b0, "R3", "no accept while bus claimed", ack_stb, 0);
    chk(busack_n == 1'b0, "R1", "busack_n granted", busack_n, 0);
    chk(bus_hiz == 1'b1, "R1", "bus_hiz granted", bus_hiz, 1);
    chk(run_en == 1'b0, "R1", "run_en during grant", run_en, 0);
    boundary(0); // R1 ignored during grant
    cyc(1);
    chk(busack_n == 1'b0, "R1", "grant held", busack_n, 0);

    // R9 short reset pulse ignored
    rst_n = 1'b0; cyc(2); rst_n = 1'b1;
    cyc(2);
    chk(busack_n == 1'b0, "R9", "grant survives short reset", busack_n, 0);

    // R2 release timing
    busreq_n = 1'b1;
    cyc(1);
    chk(busack_n == 1'b1, "R2", "busack_n released", busack_n, 1);
    chk(bus_hiz == 1'b0, "R2", "bus_hiz released", bus_hiz, 0);
    chk(run_en == 1'b0, "R2", "run_en in resume cycle", run_en, 0);
    cyc(1);
    chk(run_en == 1'b1, "R2", "run_en back", run_en, 1);
    boundary(1); // R3 pending NMI served after the grant

    // R9 full-length reset initialises
    pulse_ei();
    busreq_n = 1'b0; mc_end = 1'b1; cyc(1); mc_end = 1'b0;
    chk(busack_n == 1'b0, "R1", "second grant", busack_n, 0);
    rst_n = 1'b0;
    cyc(3);
    chk(busack_n == 1'b1, "R9", "busack_n after long reset", busack_n, 1);
    chk(ie == 1'b0, "R9", "ie after long reset", ie, 0);
    chk(run_en == 1'b1, "R9", "run_en after long reset", run_en, 1);
    rst_n = 1'b1; busreq_n = 1'b1;
    cyc(2);
    boundary(0);

    cyc(3);
    chk(exp_q.size() == 0, "R10", "expected acks left", exp_q.size(), 0);
    finish_run();
  end

endmodule